// File: doc/BRIEF.md
# MDIO Management Controller

This block lets a host run PHY management transactions over a two-wire serial management bus (clause-22 style). The host writes a few small registers: a mode word (clock ratio and preamble suppression), a PHY/register address pair and the data to write. It then writes a command word to start a read, a write or a continuous status scan. The block generates the management clock from the system clock and shifts the frame out most significant bit first. On a read it samples the PHY's reply back in.

The host polls a busy flag until the transaction finishes, then reads the result and writes the command word back to zero. In scan mode the block polls the PHY's status register (register 1) without pause. It keeps a link-fail flag and an invalid flag up to date so the host can watch link state without issuing reads.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register index map: 0 mode, 1 command, 2 address, 3 write data, 4 read data (read-only), 5 status (read-only). After reset every register reads zero, MDC is low and MDIO is released (`mdio_oe` low).
- R2: Mode bits 7:0 hold the clock ratio, and bit 0 is always stored as zero. MDC stays high for ratio/2 system clocks and low for ratio/2 system clocks. A ratio below 2 acts as 2.
- R3: A write frame is 32 ones (left out when mode bit 8 is set), then 01, then opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits, all MSB first. MDIO changes only while MDC is low, and the PHY sees each bit on the MDC rising edge.
- R4: A read frame carries opcode 10. The block drives only the preamble, start, opcode and both addresses, and releases MDIO from the turnaround onward. It samples 16 data bits on MDC rising edges into the read-data register.
- R5: Status bit 1 (busy) is set from the cycle after an accepted command until the last bit of the frame completes.
- R6: A command written while busy is ignored. The frame in progress, the command register and the read data are left unchanged, except that clearing bit 0 during a scan stops the scan.
- R7: Command bit 0 starts a scan. The block reads PHY register 1 at the programmed PHY address over and over, copies each result into read data, and sets status bit 0 (link-fail) to the inverse of bit 2 of each result.
- R8: Status bit 2 (invalid) sets when a scan starts and clears when the first scan read completes.
- R9: Once scan bit 0 is cleared, the current scan frame runs to its end, busy then falls, and MDC stays idle afterwards.
- R10: When several command bits are set at once, scan (bit 0) wins over read (bit 1), and read wins over write (bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench models a PHY that records every driven bit on MDC rising edges and answers reads after the turnaround. Against that model it checks frame contents and bit counts with and without preamble, across odd, zero and large clock ratios. A design that shifted on the wrong MDC edge, or drove through the turnaround, would show a wrong captured frame or a wrong driven-bit count. A command written mid-frame is checked for leaving the frame and the registers intact; a design that obeyed it would restart or corrupt the frame. The scan tests check that the invalid flag stays up until the first result, that link-fail follows the PHY's bit 2 both ways, and that clearing the scan bit leaves the bus quiet rather than running on.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  logic [8:0]  mode_q;
  logic [2:0]  cmd_q;
  logic [4:0]  phy_q, reg_q;
  logic [15:0] tx_q, rx_q, rsh;
  logic        busy, is_rd, scan_run, link_fail, invalid;
  logic [31:0] frame;
  logic [5:0]  pos;
  logic [6:0]  cnt, half;
  logic        tick, rise, fall, cmd_wr, start, op_rd;

  assign half   = (mode_q[7:1] == 7'd0) ? 7'd1 : mode_q[7:1];
  assign tick   = busy && (cnt == half - 7'd1);
  assign rise   = tick && !mdc;
  assign fall   = tick && mdc;
  assign cmd_wr = wr_en && (addr == 3'd1);
  assign start  = cmd_wr && !busy && (wdata[2:0] != 3'b000);
  assign op_rd  = wdata[0] | wdata[1];

  assign mdio_o  = busy && (pos[5] ? frame[~pos[4:0]] : 1'b1);
  assign mdio_oe = busy && !(is_rd && pos >= 6'd46);

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[8:0] = mode_q;
      3'd1: rdata[2:0] = cmd_q;
      3'd2: rdata[12:0] = {reg_q, 3'b000, phy_q};
      3'd3: rdata[15:0] = tx_q;
      3'd4: rdata[15:0] = rx_q;
      3'd5: rdata[2:0] = {invalid, busy, link_fail};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; cmd_q <= '0; phy_q <= '0; reg_q <= '0;
      tx_q <= '0; rx_q <= '0; rsh <= '0; frame <= '0; pos <= '0; cnt <= '0;
      busy <= 1'b0; is_rd <= 1'b0; scan_run <= 1'b0;
      link_fail <= 1'b0; invalid <= 1'b0; mdc <= 1'b0;
    end else begin
      if (wr_en && addr == 3'd0) mode_q <= {wdata[8:1], 1'b0};
      if (wr_en && addr == 3'd2) begin
        phy_q <= wdata[4:0];
        reg_q <= wdata[12:8];
      end
      if (wr_en && addr == 3'd3) tx_q <= wdata[15:0];
      if (cmd_wr && !busy) cmd_q <= wdata[2:0];
      else if (cmd_wr && scan_run && !wdata[0]) cmd_q[0] <= 1'b0;

      if (start) begin
        busy     <= 1'b1;
        is_rd    <= op_rd;
        scan_run <= wdata[0];
        if (wdata[0]) invalid <= 1'b1;
        frame    <= {2'b01, op_rd ? 2'b10 : 2'b01, phy_q,
                     wdata[0] ? 5'd1 : reg_q, 2'b10, op_rd ? 16'h0000 : tx_q};
        pos      <= mode_q[8] ? 6'd32 : 6'd0;
        cnt      <= '0;
        mdc      <= 1'b0;
      end else if (busy) begin
        if (!tick) cnt <= cnt + 7'd1;
        else begin
          cnt <= '0;
          mdc <= ~mdc;
          if (rise && is_rd && pos >= 6'd48) rsh <= {rsh[14:0], mdio_i};
          if (fall) begin
            if (pos == 6'd63) begin
              if (is_rd) rx_q <= rsh;
              if (scan_run) begin
                link_fail <= ~rsh[2];
                invalid   <= 1'b0;
              end
              if (scan_run && cmd_q[0]) pos <= mode_q[8] ? 6'd32 : 6'd0;
              else begin
                busy     <= 1'b0;
                scan_run <= 1'b0;
              end
            end else pos <= pos + 6'd1;
          end
        end
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
  a_r2_mdc_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdc)) |-> ($past(cnt) == $past(half) - 7'd1));
  a_r3_change_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);
  a_r6_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame));
  a_r8_invalid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> busy);
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe;
  int nchk = 0, nfail = 0, ncap = 0, hicnt = 0, last_hi = 0;
  logic [63:0] cap = '0;
  logic [15:0] phy_val = '0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) if (mdio_oe) begin
    cap = {cap[62:0], mdio_o};
    ncap++;
  end

  always @(negedge mdc) begin : phy_model
    int k;
    #1;
    if (!mdio_oe) begin
      k++;
      mdio_i = (k >= 3 && k <= 18) ? phy_val[18-k] : 1'b1;
    end else begin
      k = 0;
      mdio_i = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mdc) hicnt++;
    else if (hicnt != 0) begin last_hi = hicnt; hicnt = 0; end
  end

  // {write, nopre, ratio[7:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [35:0] VEC [4] = '{
    {1'b1, 1'b0, 8'd4, 5'h03, 5'h04, 16'hA5C3},
    {1'b0, 1'b0, 8'd6, 5'h1F, 5'h00, 16'h8001},
    {1'b1, 1'b1, 8'd9, 5'h00, 5'h1F, 16'h0FF0},
    {1'b0, 1'b1, 8'd0, 5'h0B, 5'h07, 16'h5A3C}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(3'd5, s);
      if (!s[1]) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [35:0] e;
    logic w, np;
    logic [7:0] dv;
    logic [4:0] ph, rg;
    logic [15:0] dt;
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset mdc/oe", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      e = VEC[i];
      w = e[35]; np = e[34]; dv = e[33:26]; ph = e[25:21]; rg = e[20:16]; dt = e[15:0];
      phy_val = dt;
      wr(3'd0, {7'b0, np, dv});
      wr(3'd2, {3'b0, rg, 3'b0, ph});
      wr(3'd3, dt);
      ncap = 0; cap = '0; last_hi = 0;
      wr(3'd1, w ? 16'd4 : 16'd2);
      rd(3'd5, v);
      chk("R5 busy after command", v[1], 1);
      wait_idle();
      chk("R2 mdc high phase", last_hi, (dv[7:1] == 0) ? 1 : dv[7:1]);
      if (w) begin
        chk("R3 write bit count", ncap, np ? 32 : 64);
        chk("R3 write frame", cap[31:0], {2'b01, 2'b01, ph, rg, 2'b10, dt});
        if (!np) chk("R3 preamble", cap[63:32], 32'hFFFF_FFFF);
      end else begin
        chk("R4 read driven count", ncap, np ? 14 : 46);
        chk("R4 read header", cap[13:0], {2'b01, 2'b10, ph, rg});
        rd(3'd4, v);
        chk("R4 read data", v, dt);
      end
      wr(3'd1, 16'd0);
    end

    wr(3'd0, 16'h0105);
    rd(3'd0, v);
    chk("R2 ratio bit0 forced zero", v, 16'h0104);

    wr(3'd3, 16'h1234);
    wr(3'd2, {3'b0, 5'h03, 3'b0, 5'h02});
    ncap = 0; cap = '0;
    wr(3'd1, 16'd4);
    wr(3'd1, 16'd2);
    wait_idle();
    chk("R6 frame unchanged", cap[31:0], {2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'h1234});
    chk("R6 one frame only", ncap, 32);
    rd(3'd1, v);
    chk("R6 command kept", v, 4);
    rd(3'd4, v);
    chk("R6 read data kept", v, 16'h5A3C);
    wr(3'd1, 16'd0);

    phy_val = 16'h0F0F;
    ncap = 0; cap = '0;
    wr(3'd1, 16'd6);
    wait_idle();
    chk("R10 read wins over write", ncap, 14);
    rd(3'd4, v);
    chk("R10 read result", v, 16'h0F0F);
    wr(3'd1, 16'd0);

    phy_val = 16'h0000;
    wr(3'd0, 16'h0102);
    ncap = 0; cap = '0;
    wr(3'd1, 16'd1);
    rd(3'd5, v);
    chk("R8 invalid and busy at scan start", v, 16'd6);
    for (int n = 0; n < 2000; n++) begin
      rd(3'd5, v);
      if (!v[2]) break;
    end
    chk("R7 link fail after first scan", v, 16'd3);
    chk("R7 scan header", cap[13:0], {2'b01, 2'b10, 5'h02, 5'h01});
    rd(3'd4, v);
    chk("R7 scan read data", v, 16'h0000);
    phy_val = 16'h0004;
    for (int n = 0; n < 2000; n++) begin
      rd(3'd5, v);
      if (!v[0]) break;
    end
    chk("R7 link restored", v, 16'd2);
    wr(3'd1, 16'd0);
    wait_idle();
    rd(3'd5, v);
    chk("R9 scan stopped", v, 16'd0);
    rd(3'd4, v);
    chk("R7 last scan data", v, 16'h0004);
    ncap = 0;
    repeat (200) @(negedge clk);
    chk("R9 bus quiet after stop", ncap, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule